// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block runs one host mailbox command each time the host sets the doorbell. The host programs a command word through a small register write port. The word holds an 8-bit command group, an 8-bit operation code and an input payload length. The host then sets the doorbell bit. The dispatcher checks the group and operation pair against a fixed table of supported operations. Each table entry gives the input length that the operation requires. An accepted command is passed to an external handler over a request/response port, and the block waits there for a return code and an output length.

When the command finishes, the block writes the return code into the status register. It rewrites the command register so that only the output length is left in it. One cycle later it drops the doorbell, and that tells the host the result can be read. The table lookup, the length check, the clamp on the handler's response and the completion sequencing are each a separate submodule. The behaviour of the individual handlers lies outside this block.

Top module: `mbx_dispatch`

## Requirements
- R1: After reset the doorbell, the command register and the status register are all zero, and `hreq_valid` is low.
- R2: The command word places the operation in bits [7:0], the group in bits [15:8] and the input length in bits [16 +: LEN_W]. With `reg_sel`=1 a write loads the command register. With `reg_sel`=0 a write loads the doorbell from `reg_wdata[0]`.
- R3: A group/operation pair that is missing from the table finishes with status 0x3. It produces no handler request and an output length of 0.
- R4: A supported pair whose supplied length differs from the required length finishes with status 0x16. It produces no handler request and an output length of 0.
- R5: The pairs 0x01/0x01 and 0x41/0x03 are marked "any length". They are dispatched whatever length is supplied, including 0.
- R6: An accepted command raises `hreq_valid` carrying the group, operation and length of the command register. The request stays high until `hrsp_valid` arrives. The handler's return code, whatever its value, becomes the status.
- R7: A handler output length above PAYLOAD_BYTES is reported as PAYLOAD_BYTES, with status 0x4. A length equal to PAYLOAD_BYTES passes through unchanged.
- R8: On completion the group and operation fields read zero and the length field holds the output length. The doorbell falls one cycle after the status and command registers are written.
- R9: While the doorbell is set, host writes to either register are ignored. This covers writes that try to clear the doorbell and writes that try to change the command word.
- R10: The required lengths are: 0x01/0x00 → 1, 0x01/0x02 → 0, 0x01/0x03 → 4, 0x02/0x00 → 0, 0x03/0x00 → 0, 0x03/0x01 → 8, 0x04/0x00 → 0, 0x04/0x01 → 0x18, 0x40/0x00 → 0, 0x41/0x00 → 0, 0x41/0x02 → 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0 = doorbell control, 1 = command register |
| reg_wdata | input | 16+LEN_W | Host write data |
| doorbell | output | 1 | Doorbell bit; high while a command is in flight |
| cmd_reg | output | 16+LEN_W | Command register contents |
| status_reg | output | ERR_W | Return code of the last command |
| hreq_valid | output | 1 | Handler request, held until response |
| hreq_grp | output | 8 | Group of the dispatched command |
| hreq_op | output | 8 | Operation of the dispatched command |
| hreq_len | output | LEN_W | Input length of the dispatched command |
| hrsp_valid | input | 1 | Handler response strobe |
| hrsp_code | input | ERR_W | Handler return code |
| hrsp_len | input | LEN_W | Handler output length |

## Verification
The case that is hardest to reach from the ports is a host write that lands while a command is still in flight. Reaching it needs a window in which the doorbell is set and the handler has not yet answered. The bench's handler model opens that window by holding its response back for ten cycles. During that wait the driver writes a different command word and a doorbell clear. The bench then checks that the doorbell stays set, that the command register is unchanged, and that the handler was given the original fields. A second hard case is an output length exactly at the buffer size, next to one just above it. The handler model returns both lengths directly.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int          NUM_OPS  = 13;
   localparam logic [15:0] LEN_ANY  = 16'hFFFF;

   localparam logic [15:0] RC_OK       = 16'h0000;
   localparam logic [15:0] RC_UNSUP    = 16'h0003;
   localparam logic [15:0] RC_INTERNAL = 16'h0004;
   localparam logic [15:0] RC_BADLEN   = 16'h0016;

   typedef struct packed {
      logic [7:0]  grp;
      logic [7:0]  op;
      logic [15:0] need;
   } op_ent_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALL = 2'd1,
      ST_WRBK = 2'd2,
      ST_DONE = 2'd3
   } seq_st_t;

   function automatic op_ent_t op_entry(input int idx);
      op_ent_t e;
      case (idx)
         0:       e = '{grp: 8'h01, op: 8'h00, need: 16'd1};
         1:       e = '{grp: 8'h01, op: 8'h01, need: LEN_ANY};
         2:       e = '{grp: 8'h01, op: 8'h02, need: 16'd0};
         3:       e = '{grp: 8'h01, op: 8'h03, need: 16'd4};
         4:       e = '{grp: 8'h02, op: 8'h00, need: 16'd0};
         5:       e = '{grp: 8'h03, op: 8'h00, need: 16'd0};
         6:       e = '{grp: 8'h03, op: 8'h01, need: 16'd8};
         7:       e = '{grp: 8'h04, op: 8'h00, need: 16'd0};
         8:       e = '{grp: 8'h04, op: 8'h01, need: 16'h18};
         9:       e = '{grp: 8'h40, op: 8'h00, need: 16'd0};
         10:      e = '{grp: 8'h41, op: 8'h00, need: 16'd0};
         11:      e = '{grp: 8'h41, op: 8'h02, need: 16'd0};
         default: e = '{grp: 8'h41, op: 8'h03, need: LEN_ANY};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/mbx_cmd_table.sv
module mbx_cmd_table
   import mbx_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic [7:0]       grp,
   input  logic [7:0]       op,
   input  logic [LEN_W-1:0] len,
   output logic             known,
   output logic             len_ok
);

   logic [NUM_OPS-1:0] hit;
   logic [NUM_OPS-1:0] fit;

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_ent
      localparam op_ent_t ENT = op_entry(g);
      assign hit[g] = (grp == ENT.grp) && (op == ENT.op);
      assign fit[g] = (ENT.need == LEN_ANY) || (32'(len) == 32'(ENT.need));
   end

   assign known  = |hit;
   assign len_ok = |(hit & fit);

endmodule

// File: rtl/mbx_rsp_clamp.sv
module mbx_rsp_clamp
   import mbx_pkg::*;
#(
   parameter int LEN_W         = 16,
   parameter int ERR_W         = 16,
   parameter int PAYLOAD_BYTES = 256
) (
   input  logic [ERR_W-1:0] in_code,
   input  logic [LEN_W-1:0] in_len,
   output logic [ERR_W-1:0] out_code,
   output logic [LEN_W-1:0] out_len
);

   localparam longint LEN_MAX = (longint'(1) << LEN_W) - 1;

   if (longint'(PAYLOAD_BYTES) >= LEN_MAX) begin : g_pass
      assign out_code = in_code;
      assign out_len  = in_len;
   end else begin : g_clamp
      localparam logic [LEN_W-1:0] CAP = LEN_W'(PAYLOAD_BYTES);
      logic over;
      assign over     = (in_len > CAP);
      assign out_code = over ? ERR_W'(RC_INTERNAL) : in_code;
      assign out_len  = over ? CAP : in_len;
   end

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
   import mbx_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bell,
   input  logic             known,
   input  logic             len_ok,
   input  logic             rsp_valid,
   input  logic [ERR_W-1:0] rsp_code,
   input  logic [LEN_W-1:0] rsp_len,
   output logic             call,
   output logic             wb,
   output logic             clr,
   output logic [ERR_W-1:0] fin_code,
   output logic [LEN_W-1:0] fin_len
);

   seq_st_t          st;
   logic [ERR_W-1:0] code_q;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         code_q <= '0;
         len_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (bell) begin
                  if (!known) begin
                     code_q <= ERR_W'(RC_UNSUP);
                     len_q  <= '0;
                     st     <= ST_WRBK;
                  end else if (!len_ok) begin
                     code_q <= ERR_W'(RC_BADLEN);
                     len_q  <= '0;
                     st     <= ST_WRBK;
                  end else begin
                     st <= ST_CALL;
                  end
               end
            end
            ST_CALL: begin
               if (rsp_valid) begin
                  code_q <= rsp_code;
                  len_q  <= rsp_len;
                  st     <= ST_WRBK;
               end
            end
            ST_WRBK: st <= ST_DONE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign call     = (st == ST_CALL);
   assign wb       = (st == ST_WRBK);
   assign clr      = (st == ST_DONE);
   assign fin_code = code_q;
   assign fin_len  = len_q;

endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch
   import mbx_pkg::*;
#(
   parameter int LEN_W         = 16,
   parameter int ERR_W         = 16,
   parameter int PAYLOAD_BYTES = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_sel,
   input  logic [16+LEN_W-1:0] reg_wdata,
   output logic                doorbell,
   output logic [16+LEN_W-1:0] cmd_reg,
   output logic [ERR_W-1:0]    status_reg,
   output logic                hreq_valid,
   output logic [7:0]          hreq_grp,
   output logic [7:0]          hreq_op,
   output logic [LEN_W-1:0]    hreq_len,
   input  logic                hrsp_valid,
   input  logic [ERR_W-1:0]    hrsp_code,
   input  logic [LEN_W-1:0]    hrsp_len
);

   localparam int CMD_W = 16 + LEN_W;

   if (LEN_W < 8 || LEN_W > 24) begin : g_bad_len
      $error("mbx_dispatch: LEN_W out of range");
   end
   if (ERR_W < 5) begin : g_bad_err
      $error("mbx_dispatch: ERR_W too narrow for return codes");
   end
   if (PAYLOAD_BYTES < 1) begin : g_bad_pl
      $error("mbx_dispatch: PAYLOAD_BYTES must be positive");
   end

   logic             known, len_ok;
   logic             wb, clr;
   logic [ERR_W-1:0] cl_code, fin_code;
   logic [LEN_W-1:0] cl_len, fin_len;

   assign hreq_op  = cmd_reg[7:0];
   assign hreq_grp = cmd_reg[15:8];
   assign hreq_len = cmd_reg[CMD_W-1:16];

   mbx_cmd_table #(.LEN_W(LEN_W)) u_table (
      .grp    (hreq_grp),
      .op     (hreq_op),
      .len    (hreq_len),
      .known  (known),
      .len_ok (len_ok)
   );

   mbx_rsp_clamp #(
      .LEN_W(LEN_W), .ERR_W(ERR_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)
   ) u_clamp (
      .in_code  (hrsp_code),
      .in_len   (hrsp_len),
      .out_code (cl_code),
      .out_len  (cl_len)
   );

   mbx_seq #(.LEN_W(LEN_W), .ERR_W(ERR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bell      (doorbell),
      .known     (known),
      .len_ok    (len_ok),
      .rsp_valid (hrsp_valid),
      .rsp_code  (cl_code),
      .rsp_len   (cl_len),
      .call      (hreq_valid),
      .wb        (wb),
      .clr       (clr),
      .fin_code  (fin_code),
      .fin_len   (fin_len)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         doorbell   <= 1'b0;
         cmd_reg    <= '0;
         status_reg <= '0;
      end else begin
         if (reg_wr && !doorbell) begin
            if (reg_sel) cmd_reg  <= reg_wdata;
            else         doorbell <= reg_wdata[0];
         end
         if (wb) begin
            cmd_reg    <= {fin_len, 16'h0000};
            status_reg <= fin_code;
         end
         if (clr) doorbell <= 1'b0;
      end
   end

endmodule

// File: rtl/mbx_dispatch_chk.sv
module mbx_dispatch_chk #(
   parameter int LEN_W         = 16,
   parameter int ERR_W         = 16,
   parameter int PAYLOAD_BYTES = 256
) (
   input logic                clk,
   input logic                rst_n,
   input logic                doorbell,
   input logic [16+LEN_W-1:0] cmd_reg,
   input logic [ERR_W-1:0]    status_reg,
   input logic                hreq_valid,
   input logic                hrsp_valid
);

   a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      hreq_valid && !hrsp_valid |=> hreq_valid);

   a_r9_req_under_bell: assert property (@(posedge clk) disable iff (!rst_n)
      hreq_valid |-> doorbell);

   a_r8_fields_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> cmd_reg[15:0] == 16'h0000);

   a_r8_written_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> $stable(cmd_reg) && $stable(status_reg));

   a_r7_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> 32'(cmd_reg[16+LEN_W-1:16]) <= 32'(PAYLOAD_BYTES));

endmodule

bind mbx_dispatch mbx_dispatch_chk #(
   .LEN_W(LEN_W), .ERR_W(ERR_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .doorbell   (doorbell),
   .cmd_reg    (cmd_reg),
   .status_reg (status_reg),
   .hreq_valid (hreq_valid),
   .hrsp_valid (hrsp_valid)
);

// File: tb/test_mbx_dispatch.sv
module test_mbx_dispatch;

   localparam int LEN_W = 16;
   localparam int ERR_W = 16;
   localparam int PB    = 256;
   localparam int CW    = 16 + LEN_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic             reg_sel = 1'b0;
   logic [CW-1:0]    reg_wdata = '0;
   logic             doorbell;
   logic [CW-1:0]    cmd_reg;
   logic [ERR_W-1:0] status_reg;
   logic             hreq_valid;
   logic [7:0]       hreq_grp, hreq_op;
   logic [LEN_W-1:0] hreq_len;
   logic             hrsp_valid = 1'b0;
   logic [ERR_W-1:0] hrsp_code = '0;
   logic [LEN_W-1:0] hrsp_len = '0;

   always #4 clk = ~clk;

   mbx_dispatch #(.LEN_W(LEN_W), .ERR_W(ERR_W), .PAYLOAD_BYTES(PB)) i_mbx_dispatch (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .doorbell(doorbell), .cmd_reg(cmd_reg),
      .status_reg(status_reg), .hreq_valid(hreq_valid), .hreq_grp(hreq_grp),
      .hreq_op(hreq_op), .hreq_len(hreq_len), .hrsp_valid(hrsp_valid),
      .hrsp_code(hrsp_code), .hrsp_len(hrsp_len)
   );

   typedef struct {
      logic [ERR_W-1:0] code;
      logic [LEN_W-1:0] olen;
      bit               call;
      logic [CW-1:0]    word;
      string            tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;

   // handler model settings
   int               h_delay = 0;
   logic [ERR_W-1:0] h_code  = '0;
   logic [LEN_W-1:0] h_len   = '0;
   int               ncalls  = 0;
   logic [CW-1:0]    h_seen  = '0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // handler responder
   initial begin
      forever begin
         @(negedge clk);
         if (hreq_valid && !hrsp_valid) begin
            ncalls++;
            h_seen = {hreq_len, hreq_grp, hreq_op};
            repeat (h_delay) @(negedge clk);
            hrsp_code  = h_code;
            hrsp_len   = h_len;
            hrsp_valid = 1'b1;
            @(negedge clk);
            hrsp_valid = 1'b0;
         end
      end
   end

   // monitor: pops expected item at each doorbell fall
   logic          db_prev = 1'b0;
   logic [CW-1:0] cmd_prev = '0;
   int            calls_at_start = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && db_prev && !doorbell) begin
            if (q.size() == 0) begin
               chk(1'b0, "R8 unexpected completion", 0, 1);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(status_reg == e.code, {e.tag, " status"}, status_reg, e.code);
               chk(cmd_reg == {e.olen, 16'h0000}, "R8 cmd register rewrite",
                   cmd_reg, {e.olen, 16'h0000});
               chk(cmd_prev == cmd_reg, "R8 bell falls after writeback", cmd_prev, cmd_reg);
               chk((ncalls - calls_at_start) == int'(e.call), {e.tag, " handler calls"},
                   ncalls - calls_at_start, int'(e.call));
               if (e.call)
                  chk(h_seen == e.word, {e.tag, " R6 request fields"}, h_seen, e.word);
            end
            calls_at_start = ncalls;
         end
         db_prev  = doorbell;
         cmd_prev = cmd_reg;
      end
   end

   task automatic put(input bit sel, input logic [CW-1:0] d);
      reg_sel   = sel;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic run(input logic [7:0] grp, input logic [7:0] op, input logic [LEN_W-1:0] len,
                      input int dly, input logic [ERR_W-1:0] rc, input logic [LEN_W-1:0] rl,
                      input logic [ERR_W-1:0] ecode, input logic [LEN_W-1:0] elen,
                      input bit ecall, input bit poke, input string tag);
      exp_t e;
      logic [CW-1:0] w;
      w = {len, grp, op};
      h_delay = dly; h_code = rc; h_len = rl;
      e.code = ecode; e.olen = elen; e.call = ecall; e.word = w; e.tag = tag;
      q.push_back(e);
      put(1'b1, w);
      put(1'b0, 1);
      if (poke) begin
         @(negedge clk); @(negedge clk);
         put(1'b1, 32'hDEAD_BEEF);
         put(1'b0, 0);
         chk(doorbell == 1'b1, "R9 clear ignored while busy", doorbell, 1);
         chk(cmd_reg == w, "R9 command write ignored while busy", cmd_reg, w);
      end
      while (doorbell) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(doorbell == 1'b0, "R1 doorbell reset", doorbell, 0);
      chk(cmd_reg == '0, "R1 command reset", cmd_reg, 0);
      chk(status_reg == '0, "R1 status reset", status_reg, 0);
      chk(hreq_valid == 1'b0, "R1 no request", hreq_valid, 0);

      run(8'h03, 8'h01, 16'd8, 0, 16'h0, 16'd0, 16'h0, 16'd0, 1, 0, "R10 R2 timestamp set");
      run(8'h03, 8'h01, 16'd7, 0, 16'h0, 16'd0, 16'h16, 16'd0, 0, 0, "R4 short length");
      run(8'h7F, 8'h00, 16'd0, 0, 16'h0, 16'd0, 16'h3, 16'd0, 0, 0, "R3 unknown group");
      run(8'h41, 8'h01, 16'd0, 0, 16'h0, 16'd0, 16'h3, 16'd0, 0, 0, "R3 gap in group");
      run(8'h01, 8'h01, 16'd123, 2, 16'h0, 16'd0, 16'h0, 16'd0, 1, 0, "R5 any length");
      run(8'h41, 8'h03, 16'd0, 1, 16'h0, 16'd0, 16'h0, 16'd0, 1, 0, "R5 any length zero");
      run(8'h04, 8'h01, 16'h18, 0, 16'h0, 16'h18, 16'h0, 16'h18, 1, 0, "R10 log read");
      run(8'h01, 8'h00, 16'd1, 3, 16'h0, 16'h20, 16'h0, 16'h20, 1, 0, "R10 records");
      run(8'h01, 8'h03, 16'd4, 0, 16'h2, 16'd0, 16'h2, 16'd0, 1, 0, "R6 code passthrough");
      run(8'h40, 8'h00, 16'd0, 0, 16'h0, 16'd300, 16'h4, 16'd256, 1, 0, "R7 over length");
      run(8'h40, 8'h00, 16'd0, 0, 16'h0, 16'd256, 16'h0, 16'd256, 1, 0, "R7 at limit");
      run(8'h40, 8'h00, 16'd1, 0, 16'h0, 16'd0, 16'h16, 16'd0, 0, 0, "R4 nonzero for zero");
      run(8'h41, 8'h02, 16'd0, 0, 16'h0, 16'd8, 16'h0, 16'd8, 1, 0, "R10 label read");
      run(8'h02, 8'h00, 16'd0, 10, 16'h0, 16'h50, 16'h0, 16'h50, 1, 1, "R9 busy poke");

      chk(q.size() == 0, "R8 all commands completed", q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule